// File: doc/BRIEF.md
# Lockable FIFO-Replacement Instruction Cache Tag Controller

This block holds the tag state of a 16 KiB instruction cache organised as 64 sets of 8 ways with 32-byte lines. For every accepted lookup it answers one cycle later with a response code and a way number. A resident line gives a hit and its way. A non-resident line gives a miss and a victim way chosen by per-line age counters, skipping locked lines. Refill data handling lives elsewhere: once a refill completes, a fill strobe writes the new tag into the chosen way.

Maintenance commands walk a run of consecutive lines from a start address, one line per clock, and invalidate, lock or unlock matching resident lines. A freeze control turns every miss into a busy or error answer instead of a refill. Dropping the enable invalidates the whole store and blocks access.

Addresses are 32 bits. Bits [4:0] are the byte offset, bits [10:5] the set index and bits [23:11] the 13-bit tag. A line is cacheable only when bits [31:24] equal the high byte of the window base, 0x42 by default.

Top module: `icache_tag_top`

## Requirements
- R1: A lookup accepted in cycle N (lkReq high while cmdBusy is low) gives rspValid high in cycle N+1. If the set holds a valid way whose tag matches, rspCode is 0 (hit) and rspWay is that way.
- R2: When an in-window lookup misses, with the cache enabled, freeze off and an eligible way present, rspCode is 1 (miss). rspWay is the lowest-numbered invalid way if any exists; otherwise it is the unlocked way with the highest age, and the lowest index wins a tie.
- R3: A fill strobe (fillReq high while idle) writes the tag of fillAddr into fillWay of its set as valid, unlocked and with age 0. Every other valid, unlocked way of that set has its age increased by one, saturating at 7.
- R4: rspCode is 4 (uncacheable) when the lookup address is outside the window, or when a miss finds all 8 ways of the set valid and locked. No way is reported for replacement in either case.
- R5: With freezeEn high and freezeMode 0, a miss is answered with rspCode 2 (busy) and no error pulse.
- R6: With freezeEn high and freezeMode 1, a miss is answered with rspCode 3 (error) and errPulse high in the same cycle as rspValid. Hits are still answered as hits while frozen.
- R7: A command starting at idle with a count of L lines keeps cmdBusy high for L+1 cycles and processes one line per cycle. cmdDone pulses for one cycle as cmdBusy falls. Lookups presented while cmdBusy is high get no response, and cmdStart is ignored while busy.
- R8: Command op 1 (invalidate) clears the valid bit of each walked line that is resident.
- R9: Command op 2 (lock) sets and op 3 (unlock) clears the lock bit of walked resident lines. A locked valid way is never chosen as a victim.
- R10: A walked line address outside the window changes no tag state.
- R11: While cacheEn is low, every entry is invalidated each cycle and lookups are answered with rspCode 5 (blocked).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cacheEn | input | 1 | Cache enable; low invalidates all entries and blocks lookups |
| freezeEn | input | 1 | Freeze: misses are rejected |
| freezeMode | input | 1 | 0 answers rejected misses busy, 1 answers them with an error |
| lkReq | input | 1 | Lookup request |
| lkAddr | input | 32 | Lookup address |
| lkReady | output | 1 | High when a lookup can be accepted |
| rspValid | output | 1 | Lookup response valid |
| rspCode | output | 3 | 0 hit, 1 miss, 2 busy, 3 error, 4 uncacheable, 5 blocked |
| rspWay | output | 3 | Hit way or victim way |
| errPulse | output | 1 | One-cycle error indication for an error response |
| fillReq | input | 1 | Refill complete; write the tag |
| fillAddr | input | 32 | Address of the refilled line |
| fillWay | input | 3 | Way to write |
| cmdStart | input | 1 | Start a maintenance command |
| cmdOp | input | 2 | 1 invalidate, 2 lock, 3 unlock, 0 no action |
| cmdAddr | input | 32 | Command start address |
| cmdLines | input | 12 | Number of lines to walk |
| cmdBusy | output | 1 | Command in progress |
| cmdDone | output | 1 | One-cycle pulse at command end |

## Verification
Corrupt tag, valid, lock or age state stays hidden until a lookup lands on the affected set. It then appears one cycle later as a wrong code or way in the response. A wrong age or lock bit shows only when a miss has to choose among full ways, so the bench fills whole sets, locks and unlocks single ways, and then probes them with misses. A walker that processes the wrong lines or the wrong number of lines shows up in the length of cmdBusy and in which lines hit afterwards.

// File: rtl/icache_tag_pkg.sv
`timescale 1ns/1ps
package icache_tag_pkg;

  typedef enum logic [2:0] {
    RSP_HIT      = 3'd0,
    RSP_MISS     = 3'd1,
    RSP_BUSY     = 3'd2,
    RSP_ERROR    = 3'd3,
    RSP_UNCACHED = 3'd4,
    RSP_BLOCKED  = 3'd5
  } rspCode_e;

  typedef enum logic [1:0] {
    MOP_NONE   = 2'd0,
    MOP_INVAL  = 2'd1,
    MOP_LOCK   = 2'd2,
    MOP_UNLOCK = 2'd3
  } maintOp_e;

  typedef struct packed {
    logic     maintEn;
    maintOp_e maintOp;
    logic     fillEn;
    logic     clearAll;
  } tagStrobe_t;

endpackage

// File: rtl/icache_tag_store.sv
`timescale 1ns/1ps
module icache_tag_store
  import icache_tag_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 16384,
  parameter int WAYS        = 8,
  parameter int LINE_BYTES  = 32,
  parameter int TAG_W       = 13,
  parameter int AGE_W       = 3,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4200_0000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tagStrobe_t              strb,
  input  logic [ADDR_W-1:0]       lkAddr,
  input  logic [ADDR_W-1:0]       fillAddr,
  input  logic [$clog2(WAYS)-1:0] fillWay,
  input  logic [ADDR_W-1:0]       maintAddr,
  output logic                    lkHit,
  output logic [$clog2(WAYS)-1:0] lkHitWay,
  output logic [$clog2(WAYS)-1:0] lkVictim,
  output logic                    lkNoVictim,
  output logic                    lkInWin
);
  localparam int SETS   = CACHE_BYTES / (WAYS * LINE_BYTES);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int SPAN_W = OFF_W + IDX_W + TAG_W;
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  logic             validMem [SETS][WAYS];
  logic             lockMem  [SETS][WAYS];
  logic [AGE_W-1:0] ageMem   [SETS][WAYS];
  logic [TAG_W-1:0] tagMem   [SETS][WAYS];

  function automatic logic inWindow(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SPAN_W] == WIN_BASE[ADDR_W-1:SPAN_W];
  endfunction

  logic [IDX_W-1:0] lkSet, fillSet, mSet;
  logic [TAG_W-1:0] lkTag, fillTag, mTag;
  logic             mInWin;

  assign lkSet   = lkAddr[OFF_W +: IDX_W];
  assign lkTag   = lkAddr[OFF_W+IDX_W +: TAG_W];
  assign fillSet = fillAddr[OFF_W +: IDX_W];
  assign fillTag = fillAddr[OFF_W+IDX_W +: TAG_W];
  assign mSet    = maintAddr[OFF_W +: IDX_W];
  assign mTag    = maintAddr[OFF_W+IDX_W +: TAG_W];
  assign mInWin  = inWindow(maintAddr);
  assign lkInWin = inWindow(lkAddr);

  // Hit search and victim choice over the ways of the looked-up set
  logic             invFound, eligFound;
  logic [WAY_W-1:0] invWay, bestWay;
  logic [AGE_W-1:0] bestAge;

  always_comb begin
    lkHit     = 1'b0;
    lkHitWay  = '0;
    invFound  = 1'b0;
    invWay    = '0;
    eligFound = 1'b0;
    bestWay   = '0;
    bestAge   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (validMem[lkSet][w] && tagMem[lkSet][w] == lkTag && !lkHit) begin
        lkHit    = 1'b1;
        lkHitWay = WAY_W'(w);
      end
      if (!validMem[lkSet][w]) begin
        if (!invFound) begin
          invFound = 1'b1;
          invWay   = WAY_W'(w);
        end
      end else if (!lockMem[lkSet][w]) begin
        if (!eligFound || ageMem[lkSet][w] > bestAge) begin
          eligFound = 1'b1;
          bestAge   = ageMem[lkSet][w];
          bestWay   = WAY_W'(w);
        end
      end
    end
    lkVictim   = invFound ? invWay : bestWay;
    lkNoVictim = !invFound && !eligFound;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          validMem[s][w] <= 1'b0;
          lockMem[s][w]  <= 1'b0;
          ageMem[s][w]   <= '0;
          tagMem[s][w]   <= '0;
        end
      end
    end else begin
      if (strb.maintEn && mInWin) begin
        for (int w = 0; w < WAYS; w++) begin
          if (validMem[mSet][w] && tagMem[mSet][w] == mTag) begin
            case (strb.maintOp)
              MOP_INVAL:  validMem[mSet][w] <= 1'b0;
              MOP_LOCK:   lockMem[mSet][w]  <= 1'b1;
              MOP_UNLOCK: lockMem[mSet][w]  <= 1'b0;
              default: ;
            endcase
          end
        end
      end
      if (strb.fillEn) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == fillWay) begin
            validMem[fillSet][w] <= 1'b1;
            lockMem[fillSet][w]  <= 1'b0;
            ageMem[fillSet][w]   <= '0;
            tagMem[fillSet][w]   <= fillTag;
          end else if (validMem[fillSet][w] && !lockMem[fillSet][w] &&
                       ageMem[fillSet][w] != AGE_MAX) begin
            ageMem[fillSet][w] <= ageMem[fillSet][w] + 1'b1;
          end
        end
      end
      if (strb.clearAll) begin
        for (int s = 0; s < SETS; s++) begin
          for (int w = 0; w < WAYS; w++) begin
            validMem[s][w] <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/icache_tag_ctrl.sv
`timescale 1ns/1ps
module icache_tag_ctrl
  import icache_tag_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 32,
  parameter int CNT_W      = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cacheEn,
  input  logic                    freezeEn,
  input  logic                    freezeMode,
  input  logic                    lkReq,
  input  logic                    fillReq,
  input  logic                    cmdStart,
  input  logic [1:0]              cmdOp,
  input  logic [ADDR_W-1:0]       cmdAddr,
  input  logic [CNT_W-1:0]        cmdLines,
  input  logic                    lkHit,
  input  logic [$clog2(WAYS)-1:0] lkHitWay,
  input  logic [$clog2(WAYS)-1:0] lkVictim,
  input  logic                    lkNoVictim,
  input  logic                    lkInWin,
  output tagStrobe_t              strb,
  output logic [ADDR_W-1:0]       maintAddr,
  output logic                    lkReady,
  output logic                    rspValid,
  output logic [2:0]              rspCode,
  output logic [$clog2(WAYS)-1:0] rspWay,
  output logic                    errPulse,
  output logic                    cmdBusy,
  output logic                    cmdDone
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int WAY_W = $clog2(WAYS);

  logic              busyQ, doneQ;
  logic [CNT_W-1:0]  remQ;
  logic [ADDR_W-1:0] curQ;
  maintOp_e          opQ;
  rspCode_e          codeNext;
  logic [WAY_W-1:0]  wayNext;
  logic              lkAccept;

  assign lkAccept  = lkReq && !busyQ;
  assign lkReady   = !busyQ;
  assign cmdBusy   = busyQ;
  assign cmdDone   = doneQ;
  assign maintAddr = curQ;

  always_comb begin
    wayNext = '0;
    if (!cacheEn)          codeNext = RSP_BLOCKED;
    else if (!lkInWin)     codeNext = RSP_UNCACHED;
    else if (lkHit) begin
      codeNext = RSP_HIT;
      wayNext  = lkHitWay;
    end
    else if (freezeEn)     codeNext = freezeMode ? RSP_ERROR : RSP_BUSY;
    else if (lkNoVictim)   codeNext = RSP_UNCACHED;
    else begin
      codeNext = RSP_MISS;
      wayNext  = lkVictim;
    end
  end

  always_comb begin
    strb.maintEn  = busyQ && (remQ != '0);
    strb.maintOp  = opQ;
    strb.fillEn   = fillReq && !busyQ;
    strb.clearAll = !cacheEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspCode  <= '0;
      rspWay   <= '0;
      errPulse <= 1'b0;
      busyQ    <= 1'b0;
      doneQ    <= 1'b0;
      remQ     <= '0;
      curQ     <= '0;
      opQ      <= MOP_NONE;
    end else begin
      rspValid <= lkAccept;
      errPulse <= lkAccept && (codeNext == RSP_ERROR);
      if (lkAccept) begin
        rspCode <= codeNext;
        rspWay  <= wayNext;
      end
      doneQ <= 1'b0;
      if (busyQ) begin
        if (remQ == '0) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          curQ <= curQ + ADDR_W'(LINE_BYTES);
          remQ <= remQ - 1'b1;
        end
      end else if (cmdStart) begin
        busyQ <= 1'b1;
        remQ  <= cmdLines;
        opQ   <= maintOp_e'(cmdOp);
        curQ  <= {cmdAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      end
    end
  end

endmodule

// File: rtl/icache_tag_top.sv
`timescale 1ns/1ps
module icache_tag_top
  import icache_tag_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CACHE_BYTES = 16384,
  parameter int WAYS        = 8,
  parameter int LINE_BYTES  = 32,
  parameter int TAG_W       = 13,
  parameter int AGE_W       = 3,
  parameter int CNT_W       = 12,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h4200_0000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cacheEn,
  input  logic                    freezeEn,
  input  logic                    freezeMode,
  input  logic                    lkReq,
  input  logic [ADDR_W-1:0]       lkAddr,
  output logic                    lkReady,
  output logic                    rspValid,
  output logic [2:0]              rspCode,
  output logic [$clog2(WAYS)-1:0] rspWay,
  output logic                    errPulse,
  input  logic                    fillReq,
  input  logic [ADDR_W-1:0]       fillAddr,
  input  logic [$clog2(WAYS)-1:0] fillWay,
  input  logic                    cmdStart,
  input  logic [1:0]              cmdOp,
  input  logic [ADDR_W-1:0]       cmdAddr,
  input  logic [CNT_W-1:0]        cmdLines,
  output logic                    cmdBusy,
  output logic                    cmdDone
);
  localparam int WAY_W = $clog2(WAYS);

  tagStrobe_t        strb;
  logic [ADDR_W-1:0] maintAddr;
  logic              lkHit, lkNoVictim, lkInWin;
  logic [WAY_W-1:0]  lkHitWay, lkVictim;

  icache_tag_ctrl #(
    .ADDR_W(ADDR_W), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .freezeEn(freezeEn),
    .freezeMode(freezeMode), .lkReq(lkReq), .fillReq(fillReq),
    .cmdStart(cmdStart), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdLines(cmdLines),
    .lkHit(lkHit), .lkHitWay(lkHitWay), .lkVictim(lkVictim),
    .lkNoVictim(lkNoVictim), .lkInWin(lkInWin), .strb(strb),
    .maintAddr(maintAddr), .lkReady(lkReady), .rspValid(rspValid),
    .rspCode(rspCode), .rspWay(rspWay), .errPulse(errPulse),
    .cmdBusy(cmdBusy), .cmdDone(cmdDone)
  );

  icache_tag_store #(
    .ADDR_W(ADDR_W), .CACHE_BYTES(CACHE_BYTES), .WAYS(WAYS),
    .LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W), .AGE_W(AGE_W), .WIN_BASE(WIN_BASE)
  ) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .lkAddr(lkAddr),
    .fillAddr(fillAddr), .fillWay(fillWay), .maintAddr(maintAddr),
    .lkHit(lkHit), .lkHitWay(lkHitWay), .lkVictim(lkVictim),
    .lkNoVictim(lkNoVictim), .lkInWin(lkInWin)
  );

endmodule

// File: rtl/icache_tag_checks.sv
`timescale 1ns/1ps
module icache_tag_checks (
  input logic       clk,
  input logic       rstN,
  input logic       cacheEn,
  input logic       freezeEn,
  input logic       lkReq,
  input logic       cmdStart,
  input logic       cmdBusy,
  input logic       cmdDone,
  input logic       rspValid,
  input logic [2:0] rspCode,
  input logic       errPulse
);

  // R7: end of a command is marked by the done pulse
  p_done_on_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdBusy) |-> cmdDone);

  // R7: done pulse only when the walker is idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |-> !cmdBusy);

  // R7: a start seen at idle makes the walker busy
  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStart && !cmdBusy) |=> cmdBusy);

  // R7: no response for a lookup presented during a command
  p_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmdBusy |=> !rspValid);

  // R6: error pulse only together with an error response
  p_err_only_error_r6: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (rspValid && rspCode == 3'd3));

  // R5: freeze never reports a refill-type miss
  p_freeze_nomiss_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lkReq && !cmdBusy && freezeEn) |=> (rspValid && rspCode != 3'd1));

  // R11: disabled cache blocks every accepted lookup
  p_blocked_r11: assert property (@(posedge clk) disable iff (!rstN)
    (lkReq && !cmdBusy && !cacheEn) |=> (rspValid && rspCode == 3'd5));

  // R1: response codes stay within the defined set
  p_code_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspCode <= 3'd5));

endmodule

bind icache_tag_top icache_tag_checks u_checks (
  .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .freezeEn(freezeEn),
  .lkReq(lkReq), .cmdStart(cmdStart), .cmdBusy(cmdBusy), .cmdDone(cmdDone),
  .rspValid(rspValid), .rspCode(rspCode), .errPulse(errPulse)
);

// File: tb/test_icache_tag_top.sv
`timescale 1ns/1ps
module test_icache_tag_top;
  localparam int SETS = 64;
  localparam int WAYS = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cacheEn = 1'b0, freezeEn = 1'b0, freezeMode = 1'b0;
  logic        lkReq = 1'b0, fillReq = 1'b0, cmdStart = 1'b0;
  logic [31:0] lkAddr = '0, fillAddr = '0, cmdAddr = '0;
  logic [2:0]  fillWay = '0;
  logic [1:0]  cmdOp = '0;
  logic [11:0] cmdLines = '0;
  logic        lkReady, rspValid, errPulse, cmdBusy, cmdDone;
  logic [2:0]  rspCode, rspWay;

  always #2.5 clk = ~clk;

  icache_tag_top i_icache_tag_top (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .freezeEn(freezeEn),
    .freezeMode(freezeMode), .lkReq(lkReq), .lkAddr(lkAddr), .lkReady(lkReady),
    .rspValid(rspValid), .rspCode(rspCode), .rspWay(rspWay), .errPulse(errPulse),
    .fillReq(fillReq), .fillAddr(fillAddr), .fillWay(fillWay),
    .cmdStart(cmdStart), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdLines(cmdLines),
    .cmdBusy(cmdBusy), .cmdDone(cmdDone)
  );

  int    checks = 0, errors = 0;
  string curReq = "R7";
  bit    cmpOn = 0;

  // Behavioural reference state
  bit          mV [SETS][WAYS];
  bit          mL [SETS][WAYS];
  int          mA [SETS][WAYS];
  int          mT [SETS][WAYS];
  bit          mBusy = 0;
  int          mRem = 0, mOp = 0;
  logic [31:0] mCur = '0;
  bit          eRspV = 0, eErr = 0, eDone = 0, eBusy = 0;
  int          eCode = 0, eWay = 0;

  function automatic logic [31:0] mk(input int tag, input int set);
    return {8'h42, 13'(tag), 6'(set), 5'b0};
  endfunction

  task automatic modelLookup(input logic [31:0] a, output int code, output int way);
    int s, t, inv, best, bestAge;
    bit hit;
    s = int'(a[10:5]); t = int'(a[23:11]);
    code = 0; way = 0; hit = 0; inv = -1; best = -1; bestAge = -1;
    for (int w = 0; w < WAYS; w++) begin
      if (mV[s][w] && mT[s][w] == t && !hit) begin hit = 1; way = w; end
      if (!mV[s][w]) begin if (inv < 0) inv = w; end
      else if (!mL[s][w] && mA[s][w] > bestAge) begin best = w; bestAge = mA[s][w]; end
    end
    if (!cacheEn) begin code = 5; way = 0; end
    else if (a[31:24] != 8'h42) begin code = 4; way = 0; end
    else if (hit) code = 0;
    else if (freezeEn) begin code = freezeMode ? 3 : 2; way = 0; end
    else if (inv >= 0) begin code = 1; way = inv; end
    else if (best >= 0) begin code = 1; way = best; end
    else begin code = 4; way = 0; end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          mV[s][w] = 0; mL[s][w] = 0; mA[s][w] = 0; mT[s][w] = 0;
        end
      mBusy = 0; mRem = 0;
      eRspV = 0; eErr = 0; eDone = 0; eBusy = 0;
    end else begin
      bit bOld;
      int c, wy;
      bOld = mBusy;
      if (lkReq && !bOld) begin
        modelLookup(lkAddr, c, wy);
        eRspV = 1; eCode = c; eWay = wy; eErr = (c == 3);
      end else begin
        eRspV = 0; eErr = 0;
      end
      eDone = 0;
      if (bOld) begin
        if (mRem == 0) begin mBusy = 0; eDone = 1; end
        else begin
          if (mCur[31:24] == 8'h42) begin
            int s, t;
            s = int'(mCur[10:5]); t = int'(mCur[23:11]);
            for (int w = 0; w < WAYS; w++)
              if (mV[s][w] && mT[s][w] == t) begin
                if (mOp == 1) mV[s][w] = 0;
                else if (mOp == 2) mL[s][w] = 1;
                else if (mOp == 3) mL[s][w] = 0;
              end
          end
          mCur = mCur + 32; mRem--;
        end
      end else if (cmdStart) begin
        mBusy = 1; mRem = int'(cmdLines); mOp = int'(cmdOp);
        mCur = {cmdAddr[31:5], 5'b0};
      end
      if (fillReq && !bOld) begin
        int s;
        s = int'(fillAddr[10:5]);
        for (int w = 0; w < WAYS; w++) begin
          if (w == int'(fillWay)) begin
            mV[s][w] = 1; mL[s][w] = 0; mA[s][w] = 0; mT[s][w] = int'(fillAddr[23:11]);
          end else if (mV[s][w] && !mL[s][w] && mA[s][w] < 7) mA[s][w]++;
        end
      end
      if (!cacheEn)
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++) mV[s][w] = 0;
      eBusy = mBusy;
    end
  end

  // Cycle-by-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (cmpOn) begin
      checks++;
      if (rspValid !== eRspV || errPulse !== eErr || cmdBusy !== eBusy ||
          cmdDone !== eDone || lkReady !== !eBusy ||
          (eRspV && (int'(rspCode) != eCode || (eCode <= 1 && int'(rspWay) != eWay)))) begin
        errors++;
        $display("FAIL %s: got v=%0b code=%0d way=%0d err=%0b busy=%0b done=%0b exp v=%0b code=%0d way=%0d err=%0b busy=%0b done=%0b",
                 curReq, rspValid, rspCode, rspWay, errPulse, cmdBusy, cmdDone,
                 eRspV, eCode, eWay, eErr, eBusy, eDone);
      end
    end
  end

  task automatic look(input logic [31:0] a);
    @(negedge clk); lkReq = 1'b1; lkAddr = a;
    @(negedge clk); lkReq = 1'b0;
  endtask

  task automatic fill(input logic [31:0] a, input int w);
    @(negedge clk); fillReq = 1'b1; fillAddr = a; fillWay = 3'(w);
    @(negedge clk); fillReq = 1'b0;
  endtask

  task automatic lookFill(input logic [31:0] a);
    look(a);
    if (eRspV && eCode == 1) fill(a, eWay);
  endtask

  task automatic cmd(input int op, input logic [31:0] a, input int n);
    @(negedge clk); cmdStart = 1'b1; cmdOp = 2'(op); cmdAddr = a; cmdLines = 12'(n);
    @(negedge clk); cmdStart = 1'b0;
    while (eBusy) @(negedge clk);
  endtask

  task automatic expectRsp(input int code, input int way, input string req);
    checks++;
    if (rspValid !== 1'b1 || int'(rspCode) != code || (code <= 1 && int'(rspWay) != way)) begin
      errors++;
      $display("FAIL %s: got v=%0b code=%0d way=%0d exp code=%0d way=%0d",
               req, rspValid, rspCode, rspWay, code, way);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got run still active exp finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmpOn = 1;
    // R7: reset state
    checks++;
    if (rspValid !== 1'b0 || cmdBusy !== 1'b0 || cmdDone !== 1'b0 || errPulse !== 1'b0) begin
      errors++;
      $display("FAIL R7 reset: got v=%0b busy=%0b done=%0b err=%0b exp all 0",
               rspValid, cmdBusy, cmdDone, errPulse);
    end
    rstN = 1'b1; cacheEn = 1'b1;
    @(negedge clk);

    curReq = "R2";
    look(mk(100, 5)); expectRsp(1, 0, "R2");
    fill(mk(100, 5), 0);
    curReq = "R1";
    look(mk(100, 5)); expectRsp(0, 0, "R1");

    curReq = "R3";
    for (int t = 1; t < 8; t++) lookFill(mk(100 + t, 5));
    look(mk(200, 5)); expectRsp(1, 0, "R3");   // oldest way is 0

    curReq = "R9";
    cmd(2, mk(100, 5), 1);
    look(mk(200, 5)); expectRsp(1, 1, "R9");   // locked way 0 skipped
    lookFill(mk(200, 5));

    curReq = "R4";
    for (int t = 100; t < 108; t++) cmd(2, mk(t, 5), 1);
    cmd(2, mk(200, 5), 1);
    look(mk(300, 5)); expectRsp(4, 0, "R4");
    look(32'h0000_1000); expectRsp(4, 0, "R4");

    curReq = "R9";
    cmd(3, mk(104, 5), 1);
    look(mk(300, 5)); expectRsp(1, 4, "R9");

    curReq = "R5";
    freezeEn = 1'b1; freezeMode = 1'b0;
    look(mk(301, 6)); expectRsp(2, 0, "R5");
    curReq = "R6";
    freezeMode = 1'b1;
    look(mk(301, 6)); expectRsp(3, 0, "R6");
    checks++;
    if (errPulse !== 1'b1) begin
      errors++; $display("FAIL R6: got err=%0b exp 1", errPulse);
    end
    look(mk(100, 5)); expectRsp(0, 0, "R6");
    freezeEn = 1'b0;

    curReq = "R8";
    for (int s = 10; s < 14; s++) fill(mk(50, s), 0);
    @(negedge clk); cmdStart = 1'b1; cmdOp = 2'd1; cmdAddr = mk(50, 10) + 32'd7; cmdLines = 12'd3;
    @(negedge clk); cmdStart = 1'b0; lkReq = 1'b1; lkAddr = mk(50, 13);  // R7 stall
    @(negedge clk); lkReq = 1'b0;
    while (eBusy) @(negedge clk);
    look(mk(50, 12)); expectRsp(1, 0, "R8");
    look(mk(50, 13)); expectRsp(0, 0, "R8");

    curReq = "R10";
    cmd(1, {8'h43, mk(50, 13)[23:0]}, 1);
    look(mk(50, 13)); expectRsp(0, 0, "R10");

    curReq = "R7";
    cmd(1, mk(50, 13), 0);
    look(mk(50, 13)); expectRsp(0, 0, "R7");

    curReq = "R11";
    @(negedge clk); cacheEn = 1'b0;
    look(mk(50, 13)); expectRsp(5, 0, "R11");
    cacheEn = 1'b1;
    look(mk(50, 13)); expectRsp(1, 0, "R11");

    curReq = "R3";
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) cmd(int'($urandom_range(1, 3)), mk(int'($urandom_range(0, 5)), int'($urandom_range(0, 3))),
                      int'($urandom_range(0, 4)));
      else if (r == 1) begin
        freezeEn = 1'b1; freezeMode = 1'($urandom_range(0, 1));
        look(mk(int'($urandom_range(0, 11)), int'($urandom_range(0, 3))));
        freezeEn = 1'b0;
      end else lookFill(mk(int'($urandom_range(0, 11)), int'($urandom_range(0, 3))));
    end

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule